// File: doc/BRIEF.md
# Watchdog / Periodic Alarm Countdown Timer

This block holds one 24-bit down-counter that plays one of three roles, chosen through a small control register. It can be a periodic alarm that counts whole seconds and reloads itself each time it runs out. It can be a one-shot watchdog that counts at 4096 Hz and halts when it expires. With the counter disabled, it is simply three bytes of read/write storage. The host reaches the block over a plain register bus with a write strobe, a read/access strobe, an address and byte-wide data. The host keeps a watchdog alive by touching any of the three reload bytes. Every such access re-arms the count from the programmed value.

The block has two timing inputs: a single-cycle strobe at 4096 Hz and a single-cycle strobe at 1 Hz. Expiry of the count sets a sticky alarm flag. The flag can raise an active-low interrupt line, but only when enabled. A watchdog expiry also produces an active-low pulse lasting 1024 fast ticks (250 ms). A steering bit sends that pulse either to the reset line or to the interrupt line.

Top module: `cdt_top`

## Requirements
- R1: After reset the control register reads 0x06, the three reload bytes and the status register read 0x00, and both irqN and rstOutN are high.
- R2: With the counter-enable bit (control bit 6) at 0, the reload bytes behave as plain storage that reads back what was written. Ticks on either tick input then never set the alarm flag.
- R3: In alarm mode (control bit 5 = 0), the counter steps on tick1 only. Fast ticks have no effect. With a reload value N, the flag sets on the N-th tick1 after the count is loaded. The counter reloads N at that point and repeats.
- R4: In watchdog mode (control bit 5 = 1), the counter steps on tick4k. The flag sets on the N-th tick4k after loading. The counter then stops, so later ticks set nothing until it is re-armed.
- R5: A read or a write at any reload-byte address (0, 1, 2), or a control write that turns the enable bit from 0 to 1, re-arms the counter. The count is reloaded on the next tick of the active rate, which delays expiry.
- R6: A watchdog expiry drives one output low for exactly 1024 tick4k strobes. That output is rstOutN when the steering bit (control bit 3) is 0 and irqN when it is 1. The other line stays high.
- R7: The alarm flag pulls irqN low only while both the interrupt-enable bit (control bit 0) and the intCtl input are 1.
- R8: Clearing the interrupt-enable bit during a watchdog pulse steered to irqN does not shorten that pulse.
- R9: The alarm flag is status register (address 4) bit 0. Writing 0 to that bit clears the flag, and writing 1 leaves it unchanged. A set on expiry wins over a clear in the same cycle.
- R10: Address map: reload bytes at 0 to 2, least significant first; control at 3; status at 4. Control bits 7, 4, 2 and 1 are stored and read back with no effect on this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick4k | input | 1 | One-cycle strobe at 4096 Hz |
| tick1 | input | 1 | One-cycle strobe at 1 Hz |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read/access strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| intCtl | input | 1 | Interrupt-control mode; 1 lets the flag reach irqN |
| alarmFlag | output | 1 | Sticky alarm flag |
| irqN | output | 1 | Active-low interrupt request |
| rstOutN | output | 1 | Active-low reset pulse |

## Verification
The counter itself cannot be read. A wrong count, a lost re-arm or a missed reload therefore shows up only as the alarm flag rising on the wrong tick. The bench checks the flag on the tick just before and the tick of the expected expiry. A wrong pulse-length counter or a mis-latched steering bit shows up on rstOutN or irqN exactly 1024 fast ticks after expiry. Failing to stop in watchdog mode, or leaking fast ticks into alarm mode, gives a second flag within a few ticks of a clear.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef struct packed {
    logic       oscOff;
    logic       cntEn;
    logic       wdMode;
    logic       bbSq;
    logic       steerIrq;
    logic [1:0] rate;
    logic       aie;
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h06;

  typedef struct packed {
    logic kick;
    logic step;
    logic wdMode;
    logic en;
  } pathStb_t;

  localparam int ADDR_CTRL = 3;
  localparam int ADDR_STAT = 4;

endpackage

// File: rtl/cdt_path.sv
module cdt_path
  import cdt_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathStb_t         stb,
  input  logic [WIDTH-1:0] reloadVal,
  output logic [WIDTH-1:0] count,
  output logic             zeroEvt
);

  logic pend;
  logic running;

  // Expiry happens on the tick that would take the count to zero.
  assign zeroEvt = stb.step && !pend && running && (count <= WIDTH'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      pend    <= 1'b0;
      running <= 1'b0;
    end else begin
      pend <= stb.kick || (pend && !stb.step);
      if (stb.step && pend) begin
        count   <= reloadVal;
        running <= 1'b1;
      end else if (zeroEvt) begin
        if (stb.wdMode) begin
          count   <= '0;
          running <= 1'b0;
        end else begin
          count <= reloadVal;
        end
      end else if (stb.step && running) begin
        count <= count - WIDTH'(1);
      end
    end
  end

endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int WIDTH       = 24,
  parameter int PULSE_TICKS = 1024,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick4k,
  input  logic              tick1,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              intCtl,
  input  logic              zeroEvt,
  output logic [WIDTH-1:0]  reloadVal,
  output pathStb_t          stb,
  output logic              alarmFlag,
  output logic              irqN,
  output logic              rstOutN
);

  localparam int NB = WIDTH / 8;
  localparam int PW = $clog2(PULSE_TICKS + 1);

  ctrl_t          ctrl;
  logic [7:0]     rlByte [NB];
  logic [PW-1:0]  pulseCnt;
  logic           pulseToIrq;
  logic           byteHit;
  logic           ctrlWr;
  logic           enRise;
  logic           pulseOn;

  assign byteHit = busAddr < ADDR_W'(NB);
  assign ctrlWr  = busWr && (busAddr == ADDR_W'(ADDR_CTRL));
  assign enRise  = ctrlWr && busWdata[6] && !ctrl.cntEn;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rlByte[b] <= 8'h00;
      else if (busWr && busAddr == ADDR_W'(b))
        rlByte[b] <= busWdata;
    end
    assign reloadVal[8*b +: 8] = rlByte[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ctrl <= ctrl_t'(CTRL_RESET);
    else if (ctrlWr)
      ctrl <= ctrl_t'(busWdata);
  end

  always_comb begin
    stb.kick   = ((busWr || busRd) && byteHit) || enRise;
    stb.en     = ctrl.cntEn;
    stb.wdMode = ctrl.wdMode;
    stb.step   = ctrl.cntEn && (ctrl.wdMode ? tick4k : tick1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      alarmFlag <= 1'b0;
    else if (zeroEvt)
      alarmFlag <= 1'b1;
    else if (busWr && busAddr == ADDR_W'(ADDR_STAT) && !busWdata[0])
      alarmFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt   <= '0;
      pulseToIrq <= 1'b0;
    end else if (zeroEvt && ctrl.wdMode) begin
      pulseCnt   <= PW'(PULSE_TICKS);
      pulseToIrq <= ctrl.steerIrq;
    end else if (tick4k && pulseCnt != '0) begin
      pulseCnt <= pulseCnt - PW'(1);
    end
  end

  assign pulseOn = pulseCnt != '0;
  assign rstOutN = !(pulseOn && !pulseToIrq);
  assign irqN    = !((pulseOn && pulseToIrq) || (alarmFlag && ctrl.aie && intCtl));

  always_comb begin
    busRdata = 8'h00;
    for (int b = 0; b < NB; b++)
      if (busAddr == ADDR_W'(b)) busRdata = rlByte[b];
    if (busAddr == ADDR_W'(ADDR_CTRL)) busRdata = ctrl;
    if (busAddr == ADDR_W'(ADDR_STAT)) busRdata = {7'b0, alarmFlag};
  end

endmodule

// File: rtl/cdt_top.sv
module cdt_top
  import cdt_pkg::*;
#(
  parameter int WIDTH       = 24,
  parameter int PULSE_TICKS = 1024,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick4k,
  input  logic              tick1,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              intCtl,
  output logic              alarmFlag,
  output logic              irqN,
  output logic              rstOutN
);

  pathStb_t         stb;
  logic [WIDTH-1:0] reloadVal;
  logic [WIDTH-1:0] count;
  logic             zeroEvt;

  cdt_ctrl #(.WIDTH(WIDTH), .PULSE_TICKS(PULSE_TICKS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick4k(tick4k), .tick1(tick1),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .intCtl(intCtl), .zeroEvt(zeroEvt),
    .reloadVal(reloadVal), .stb(stb), .alarmFlag(alarmFlag),
    .irqN(irqN), .rstOutN(rstOutN)
  );

  cdt_path #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .reloadVal(reloadVal),
    .count(count), .zeroEvt(zeroEvt)
  );

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker
  import cdt_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input logic             clk,
  input logic             rstN,
  input pathStb_t         stb,
  input logic             zeroEvt,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] reloadVal,
  input logic             busWr,
  input logic             alarmFlag,
  input logic             rstOutN
);

  // R2: a disabled counter keeps its value
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !stb.en |=> $stable(count));

  // R3: alarm expiry reloads the programmed value
  a_r3_alarm_reload: assert property (@(posedge clk) disable iff (!rstN)
    (zeroEvt && !stb.wdMode && !busWr) |=> count == reloadVal);

  // R4: watchdog expiry parks the count at zero
  a_r4_wd_stops: assert property (@(posedge clk) disable iff (!rstN)
    (zeroEvt && stb.wdMode) |=> count == '0);

  // R9: expiry always leaves the flag set
  a_r9_flag_on_expiry: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvt |=> alarmFlag);

  // R6: the reset pulse lasts longer than one cycle
  a_r6_pulse_not_glitch: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOutN) |=> !rstOutN);

endmodule

bind cdt_top cdt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .zeroEvt(zeroEvt), .count(count),
  .reloadVal(reloadVal), .busWr(busWr), .alarmFlag(alarmFlag), .rstOutN(rstOutN)
);

// File: tb/tb_cdt_top.sv
module tb_cdt_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick4k, tick1, busWr, busRd, intCtl;
  logic [2:0] busAddr;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic       alarmFlag, irqN, rstOutN;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdt_top dut (
    .clk(clk), .rstN(rstN), .tick4k(tick4k), .tick1(tick1),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .intCtl(intCtl), .alarmFlag(alarmFlag),
    .irqN(irqN), .rstOutN(rstOutN)
  );

  // {isWrite, addr, data, expected read}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd3, 8'h00, 8'h06},  // R1 control reset, R10 address
    {1'b0, 3'd0, 8'h00, 8'h00},  // R1
    {1'b0, 3'd2, 8'h00, 8'h00},  // R1
    {1'b0, 3'd4, 8'h00, 8'h00},  // R1 status
    {1'b1, 3'd0, 8'hA5, 8'h00},
    {1'b1, 3'd1, 8'h3C, 8'h00},
    {1'b1, 3'd2, 8'h7E, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'hA5},  // R2 storage
    {1'b0, 3'd1, 8'h00, 8'h3C},  // R2
    {1'b0, 3'd2, 8'h00, 8'h7E},  // R2
    {1'b1, 3'd3, 8'h96, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h96},  // R10 unused bits stored
    {1'b1, 3'd3, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic fastTicks(input int n);
    for (int i = 0; i < n; i++) begin
      tick4k = 1'b1;
      @(negedge clk);
      tick4k = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic slowTicks(input int n);
    for (int i = 0; i < n; i++) begin
      tick1 = 1'b1;
      @(negedge clk);
      tick1 = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    rstN = 1'b0; tick4k = 0; tick1 = 0; busWr = 0; busRd = 0;
    busAddr = '0; busWdata = '0; intCtl = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irqN", irqN, 1);
    check("R1 rstOutN", rstOutN, 1);
    check("R1 flag", alarmFlag, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][19]) busWrite(VEC[v][18:16], VEC[v][15:8]);
      else begin
        busRead(VEC[v][18:16], rd);
        check($sformatf("R1/R2/R10 vec%0d", v), rd, VEC[v][7:0]);
      end
    end

    // R2: disabled counter never flags
    slowTicks(20); fastTicks(20);
    check("R2 no flag when disabled", alarmFlag, 0);
    busRead(3'd0, rd);
    check("R2 storage kept", rd, 8'hA5);

    // R3: alarm mode, reload 3
    busWrite(3'd0, 8'd3); busWrite(3'd1, 8'd0); busWrite(3'd2, 8'd0);
    busWrite(3'd3, 8'h41);
    slowTicks(1);
    slowTicks(2);
    check("R3 no flag before Nth tick", alarmFlag, 0);
    slowTicks(1);
    check("R3 flag on Nth tick", alarmFlag, 1);
    check("R7 irq with aie and intCtl", irqN, 0);
    busWrite(3'd4, 8'h00);
    check("R9 flag cleared", alarmFlag, 0);
    fastTicks(10);
    slowTicks(2);
    check("R3 fast ticks ignored, no early flag", alarmFlag, 0);
    slowTicks(1);
    check("R3 periodic repeat", alarmFlag, 1);

    // R7 gating
    intCtl = 1'b0; #1;
    check("R7 intCtl=0 masks", irqN, 1);
    intCtl = 1'b1; #1;
    check("R7 intCtl=1 passes", irqN, 0);
    busWrite(3'd3, 8'h40);
    check("R7 aie=0 masks", irqN, 1);
    busWrite(3'd4, 8'h01);
    check("R9 write 1 keeps flag", alarmFlag, 1);
    busWrite(3'd4, 8'h00);
    check("R9 write 0 clears", alarmFlag, 0);

    // R4/R6: watchdog, reload 5, steer to reset
    busWrite(3'd3, 8'h60);
    busWrite(3'd0, 8'd5);
    fastTicks(1);
    fastTicks(4);
    check("R4 no flag before Nth tick", alarmFlag, 0);
    check("R6 rstOutN idle", rstOutN, 1);
    fastTicks(1);
    check("R4 flag on Nth tick", alarmFlag, 1);
    check("R6 rstOutN pulse", rstOutN, 0);
    check("R6 irqN untouched", irqN, 1);
    fastTicks(1023);
    check("R6 pulse still low at 1023", rstOutN, 0);
    fastTicks(1);
    check("R6 pulse ends at 1024", rstOutN, 1);
    busWrite(3'd4, 8'h00);
    fastTicks(20);
    check("R4 stopped after expiry", alarmFlag, 0);

    // R5: accesses re-arm
    busRead(3'd0, rd);
    fastTicks(1);
    fastTicks(3);
    busRead(3'd1, rd);
    fastTicks(1);
    fastTicks(4);
    check("R5 read access deferred expiry", alarmFlag, 0);
    fastTicks(1);
    check("R5 expiry after re-arm", alarmFlag, 1);
    fastTicks(1024);
    busWrite(3'd4, 8'h00);

    // R6/R8: steer to interrupt, clear aie mid-pulse
    busWrite(3'd3, 8'h69);
    busWrite(3'd0, 8'd2);
    fastTicks(1);
    fastTicks(2);
    check("R6 steered pulse on irqN", irqN, 0);
    check("R6 rstOutN stays high", rstOutN, 1);
    busWrite(3'd3, 8'h68);
    check("R8 aie clear keeps pulse", irqN, 0);
    fastTicks(1023);
    check("R8 pulse held to 1023", irqN, 0);
    fastTicks(1);
    check("R8 pulse ends, flag masked", irqN, 1);

    finishRun();
  end

endmodule